// File: doc/BRIEF.md
# Machine Cycle Sequencer with DMA and Interrupt Insertion

This block is the cycle-level controller of a small 8-bit processor. It steps the machine through fetch (S0), execute (S1), stolen memory-access (S2) and interrupt-response (S3) cycles, and reports the current cycle type on a 2-bit state code. At each execute boundary it arbitrates between inbound DMA, outbound DMA and interrupt requests. It owns the DMA pointer R0, the X and P nibbles, the T save register and the interrupt-enable flag. Instruction decode is reduced to three stub inputs: an execute-hold level, for an instruction that idles in S1, and RETURN and DISABLE pulses.

Each clock edge ends one machine cycle, and requests are sampled once per cycle at that edge. A CLEAR level forces the start-up state. Releasing it runs one empty S2 cycle and then begins fetching. With CLEAR and LOAD both held, the machine idles and stores each inbound DMA byte at the next consecutive address from zero, which gives a built-in program loader.

Top module: `cycle_sequencer`

## Requirements
- R1: While `rst` is high, and from the edge after `clear` is first seen high, P is 0, R0 is 0 and IE is 1. A held clear without a load transfer shows state code 01.
- R2: After clear (or reset) is released, exactly one S2 cycle follows with neither memory strobe active and R0 unchanged. The next cycle is S0.
- R3: The state code `{sc1,sc0}` is 00 for S0, 01 for S1, 10 for S2 and 11 for S3. S0 is always followed by S1. S1, with no request and no hold, is followed by S0.
- R4: While `stayInExec` is high at an S1 boundary, with no request granted, the next cycle is S1 again.
- R5: A request raised during S0 is not served in the next cycle, which is S1. DMA and interrupt cycles follow only S1 or S2.
- R6: An inbound S2 asserts `memWr` with `memAddr` equal to R0 and `memWdata` equal to `busIn`. R0 is one higher in the next cycle. While `dmaIn` stays high, S2 cycles follow back to back.
- R7: An outbound S2 asserts `memRd`, and `busOut` carries `memRdData`. R0 is one higher in the next cycle.
- R8: Priority at a boundary is inbound DMA first, then outbound DMA, then interrupt.
- R9: An S3 cycle is followed by S0. In that S0, T holds the previous `{X,P}`, P is 1, X is 2 and IE is 0.
- R10: With IE at 0, `intReq` has no effect on the cycle sequence. A RETURN pulse sets IE to 1 and a DISABLE pulse sets it to 0 at the next edge. Both pulses are ignored while clear is in force.
- R11: With `clear` and `load` high, each cycle with `dmaIn` high is an inbound S2 cycle at consecutive addresses starting at 0. Without `dmaIn`, the machine idles in S1.
- R12: R0 wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per machine cycle |
| rst | input | 1 | Asynchronous power-on reset, active high |
| clear | input | 1 | Clear mode level |
| load | input | 1 | Program-load mode, effective with clear |
| dmaIn | input | 1 | Inbound DMA request |
| dmaOut | input | 1 | Outbound DMA request |
| intReq | input | 1 | Interrupt request |
| stayInExec | input | 1 | Decode stub: repeat the execute cycle |
| retPulse | input | 1 | Decode stub: RETURN, sets IE |
| disPulse | input | 1 | Decode stub: DISABLE, clears IE |
| busIn | input | DATA_W | Data bus from the I/O device |
| memRdData | input | DATA_W | Memory read data |
| stateCode | output | 2 | Cycle type {sc1,sc0} |
| memWr | output | 1 | Memory write strobe in inbound S2 |
| memRd | output | 1 | Memory read strobe in outbound S2 |
| memAddr | output | ADDR_W | DMA address (R0) |
| memWdata | output | DATA_W | Memory write data |
| busOut | output | DATA_W | Data toward the I/O device in outbound S2 |
| regX | output | NIB_W | X nibble |
| regP | output | NIB_W | P nibble |
| regT | output | 2*NIB_W | Save register T |
| ieFlag | output | 1 | Interrupt enable |

## Verification
The bench builds the block with ADDR_W set to 4 and all other parameters at their defaults. A 4-bit pointer wraps after sixteen DMA bytes. A single load burst of seventeen bytes therefore reaches the R0 rollover, which a 16-bit pointer would need over 65,000 transfers to hit. The default DATA_W and NIB_W let the bench check the interrupt save value 0x21 exactly, and watch bytes pass unchanged between bus and memory in both directions.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [1:0] {
    CYC_S0 = 2'b00,
    CYC_S1 = 2'b01,
    CYC_S2 = 2'b10,
    CYC_S3 = 2'b11
  } cycT;

  typedef enum logic [1:0] {
    K_NOP = 2'b00,
    K_IN  = 2'b01,
    K_OUT = 2'b10
  } kindT;

  typedef struct packed {
    logic clrRegs;
    logic incR0;
    logic doIntr;
    logic setIe;
    logic clrIe;
  } ctrlT;

endpackage

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
  import cyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       load,
  input  logic       dmaIn,
  input  logic       dmaOut,
  input  logic       intReq,
  input  logic       stayInExec,
  input  logic       retPulse,
  input  logic       disPulse,
  input  logic       ieQ,
  output ctrlT       ctrl,
  output logic [1:0] stateCode,
  output logic       memWr,
  output logic       memRd
);

  cycT  cycQ, cycN;
  kindT kindQ, kindN;
  logic inClearQ;
  logic running;

  assign running = !clear && !inClearQ;

  // choose the cycle that follows an S1 or S2 boundary
  function automatic void arbitrate(input logic fallbackExec,
                                    output cycT c, output kindT k);
    if (dmaIn) begin
      c = CYC_S2; k = K_IN;
    end else if (dmaOut) begin
      c = CYC_S2; k = K_OUT;
    end else if (intReq && ieQ) begin
      c = CYC_S3; k = K_NOP;
    end else if (fallbackExec) begin
      c = CYC_S1; k = K_NOP;
    end else begin
      c = CYC_S0; k = K_NOP;
    end
  endfunction

  always_comb begin
    cycN  = CYC_S0;
    kindN = K_NOP;
    if (clear) begin
      if (load && dmaIn) begin
        cycN = CYC_S2; kindN = K_IN;
      end else begin
        cycN = CYC_S1; kindN = K_NOP;
      end
    end else if (inClearQ) begin
      cycN = CYC_S2; kindN = K_NOP;
    end else begin
      unique case (cycQ)
        CYC_S0: begin cycN = CYC_S1; kindN = K_NOP; end
        CYC_S1: arbitrate(stayInExec, cycN, kindN);
        CYC_S2: arbitrate(1'b0, cycN, kindN);
        CYC_S3: begin cycN = CYC_S0; kindN = K_NOP; end
        default: begin cycN = CYC_S0; kindN = K_NOP; end
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cycQ     <= CYC_S1;
      kindQ    <= K_NOP;
      inClearQ <= 1'b1;
    end else begin
      cycQ     <= cycN;
      kindQ    <= kindN;
      inClearQ <= clear;
    end
  end

  assign memWr = (cycQ == CYC_S2) && (kindQ == K_IN);
  assign memRd = (cycQ == CYC_S2) && (kindQ == K_OUT);
  assign stateCode = cycQ;

  assign ctrl.clrRegs = clear && !inClearQ;
  assign ctrl.incR0   = (cycQ == CYC_S2) && (kindQ != K_NOP);
  assign ctrl.doIntr  = (cycQ == CYC_S3) && running;
  assign ctrl.setIe   = retPulse && running;
  assign ctrl.clrIe   = disPulse && running;

endmodule

// File: rtl/cyc_regs.sv
module cyc_regs
  import cyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4,
  parameter int INT_P  = 1,
  parameter int INT_X  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlT                 ctrl,
  output logic [ADDR_W-1:0]    r0Q,
  output logic [NIB_W-1:0]     xQ,
  output logic [NIB_W-1:0]     pQ,
  output logic [2*NIB_W-1:0]   tQ,
  output logic                 ieQ
);

  localparam logic [ADDR_W-1:0] R0_ONE = ADDR_W'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      r0Q <= '0;
      xQ  <= '0;
      pQ  <= '0;
      tQ  <= '0;
      ieQ <= 1'b1;
    end else if (ctrl.clrRegs) begin
      r0Q <= '0;
      pQ  <= '0;
      ieQ <= 1'b1;
    end else begin
      if (ctrl.incR0) r0Q <= r0Q + R0_ONE;
      if (ctrl.doIntr) begin
        tQ  <= {xQ, pQ};
        pQ  <= NIB_W'(INT_P);
        xQ  <= NIB_W'(INT_X);
        ieQ <= 1'b0;
      end else if (ctrl.clrIe) begin
        ieQ <= 1'b0;
      end else if (ctrl.setIe) begin
        ieQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
  import cyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  parameter int INT_P  = 1,
  parameter int INT_X  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 load,
  input  logic                 dmaIn,
  input  logic                 dmaOut,
  input  logic                 intReq,
  input  logic                 stayInExec,
  input  logic                 retPulse,
  input  logic                 disPulse,
  input  logic [DATA_W-1:0]    busIn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [1:0]           stateCode,
  output logic                 memWr,
  output logic                 memRd,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    busOut,
  output logic [NIB_W-1:0]     regX,
  output logic [NIB_W-1:0]     regP,
  output logic [2*NIB_W-1:0]   regT,
  output logic                 ieFlag
);

  ctrlT ctrl;
  logic ieQ;

  cyc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clear(clear), .load(load),
    .dmaIn(dmaIn), .dmaOut(dmaOut), .intReq(intReq),
    .stayInExec(stayInExec), .retPulse(retPulse), .disPulse(disPulse),
    .ieQ(ieQ), .ctrl(ctrl), .stateCode(stateCode),
    .memWr(memWr), .memRd(memRd)
  );

  cyc_regs #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .INT_P(INT_P), .INT_X(INT_X)) u_regs (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .r0Q(memAddr), .xQ(regX), .pQ(regP), .tQ(regT), .ieQ(ieQ)
  );

  assign ieFlag   = ieQ;
  assign memWdata = busIn;
  assign busOut   = memRd ? memRdData : '0;

endmodule

// File: rtl/cyc_checker.sv
module cyc_checker #(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic              dmaIn,
  input logic              dmaOut,
  input logic              intReq,
  input logic [1:0]        stateCode,
  input logic              memWr,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [NIB_W-1:0]  regX,
  input logic [NIB_W-1:0]  regP,
  input logic              ieFlag
);

  logic [ADDR_W-1:0] addrNext;
  assign addrNext = memAddr + ADDR_W'(1);

  p_clear_regs_r1: assert property (@(posedge clk) disable iff (rst)
    clear |=> (regP == '0 && ieFlag));

  p_release_nop_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(clear) |=> (stateCode == 2'b10 && !memWr && !memRd));

  p_fetch_then_exec_r3: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b00 && !clear) |=> stateCode == 2'b01);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(memWr && memRd));

  p_strobe_in_s2_r7: assert property (@(posedge clk) disable iff (rst)
    (memWr || memRd) |-> stateCode == 2'b10);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    ((memWr || memRd) && !clear) |=> memAddr == $past(addrNext));

  p_intr_result_r9: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b11 && !clear) |=>
      (stateCode == 2'b00 && regP == NIB_W'(1) && regX == NIB_W'(2) && !ieFlag));

  p_masked_intr_r10: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b01 && !clear && intReq && !ieFlag && !dmaIn && !dmaOut)
      |=> stateCode != 2'b11);

endmodule

bind cycle_sequencer cyc_checker #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .dmaIn(dmaIn), .dmaOut(dmaOut),
  .intReq(intReq), .stateCode(stateCode), .memWr(memWr), .memRd(memRd),
  .memAddr(memAddr), .regX(regX), .regP(regP), .ieFlag(ieFlag)
);

// File: tb/sim_cycle_sequencer.sv
module sim_cycle_sequencer;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst, clear, load, dmaIn, dmaOut, intReq, stayInExec, retPulse, disPulse;
  logic [DW-1:0] busIn, memRdData;
  logic [1:0]    stateCode;
  logic          memWr, memRd, ieFlag;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, busOut;
  logic [NW-1:0] regX, regP;
  logic [2*NW-1:0] regT;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  assign memRdData = 8'hC0 | {4'h0, memAddr};

  cycle_sequencer #(.ADDR_W(AW), .DATA_W(DW), .NIB_W(NW)) u0 (
    .clk(clk), .rst(rst), .clear(clear), .load(load), .dmaIn(dmaIn),
    .dmaOut(dmaOut), .intReq(intReq), .stayInExec(stayInExec),
    .retPulse(retPulse), .disPulse(disPulse), .busIn(busIn),
    .memRdData(memRdData), .stateCode(stateCode), .memWr(memWr),
    .memRd(memRd), .memAddr(memAddr), .memWdata(memWdata), .busOut(busOut),
    .regX(regX), .regP(regP), .regT(regT), .ieFlag(ieFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; clear = 0; load = 0; dmaIn = 0; dmaOut = 0; intReq = 0;
    stayInExec = 0; retPulse = 0; disPulse = 0; busIn = '0;
    repeat (3) tick();
    check("R1 code", stateCode, 2'b01);
    check("R1 r0", memAddr, 0);
    check("R1 P", regP, 0);
    check("R1 IE", ieFlag, 1);
    rst = 1'b0;
    tick();
    check("R2 nop S2", stateCode, 2'b10);
    check("R2 no strobe", {memWr, memRd}, 2'b00);
    check("R2 r0", memAddr, 0);
    tick();
    check("R2 then S0", stateCode, 2'b00);
    tick();
    check("R3 S1", stateCode, 2'b01);
  endtask

  task automatic t_fetch();
    for (int i = 0; i < 2; i++) begin
      tick(); check("R3 S0", stateCode, 2'b00);
      tick(); check("R3 S1", stateCode, 2'b01);
    end
  endtask

  task automatic t_hold();
    stayInExec = 1;
    tick(); check("R4 hold", stateCode, 2'b01);
    tick(); check("R4 hold", stateCode, 2'b01);
    stayInExec = 0;
    tick(); check("R4 release", stateCode, 2'b00);
  endtask

  task automatic t_dma_in();
    dmaIn = 1; busIn = 8'h5A;
    tick(); check("R5 no insert after S0", stateCode, 2'b01);
    tick(); check("R6 S2", stateCode, 2'b10);
    check("R6 wr", {memWr, memRd}, 2'b10);
    check("R6 addr", memAddr, 0);
    check("R6 data", memWdata, 8'h5A);
    busIn = 8'hA5;
    tick(); check("R6 back to back", stateCode, 2'b10);
    check("R6 addr2", memAddr, 1);
    check("R6 data2", memWdata, 8'hA5);
    dmaIn = 0;
    tick(); check("R6 resume", stateCode, 2'b00);
    check("R6 r0", memAddr, 2);
    tick();
  endtask

  task automatic t_dma_out();
    dmaOut = 1;
    tick(); check("R7 S2", stateCode, 2'b10);
    check("R7 rd", {memWr, memRd}, 2'b01);
    check("R7 bus", busOut, 8'hC2);
    dmaOut = 0;
    tick(); check("R7 resume", stateCode, 2'b00);
    check("R7 r0", memAddr, 3);
    tick();
  endtask

  task automatic t_prio();
    dmaIn = 1; dmaOut = 1; intReq = 1;
    tick(); check("R8 in first", {memWr, memRd}, 2'b10);
    dmaIn = 0;
    tick(); check("R8 out second", {memWr, memRd}, 2'b01);
    dmaOut = 0;
    tick(); check("R8 intr last", stateCode, 2'b11);
    check("R9 P held in S3", regP, 0);
    intReq = 0;
    tick(); check("R9 S0 after S3", stateCode, 2'b00);
    check("R9 P", regP, 1);
    check("R9 X", regX, 2);
    check("R9 T", regT, 8'h00);
    check("R9 IE", ieFlag, 0);
    tick();
  endtask

  task automatic t_ie();
    intReq = 1;
    tick(); check("R10 masked", stateCode, 2'b00);
    tick(); tick(); check("R10 masked again", stateCode, 2'b00);
    retPulse = 1;
    tick(); check("R10 return sets", ieFlag, 1);
    retPulse = 0;
    tick(); check("R10 intr taken", stateCode, 2'b11);
    intReq = 0;
    tick(); check("R9 T save", regT, 8'h21);
    check("R9 IE cleared", ieFlag, 0);
    retPulse = 1;
    tick(); check("R10 return", ieFlag, 1);
    retPulse = 0; disPulse = 1;
    tick(); check("R10 disable", ieFlag, 0);
    disPulse = 0;
  endtask

  task automatic t_clear_load();
    clear = 1; disPulse = 1;
    tick(); check("R1 clear code", stateCode, 2'b01);
    check("R1 clear P", regP, 0);
    check("R1 clear r0", memAddr, 0);
    check("R1 clear IE", ieFlag, 1);
    tick(); check("R10 pulse ignored in clear", ieFlag, 1);
    disPulse = 0;
    load = 1;
    tick(); check("R11 idle without request", {stateCode, memWr}, 3'b010);
    dmaIn = 1;
    for (int i = 0; i < 17; i++) begin
      busIn = 8'(i + 8'h10);
      tick();
      check("R11 load S2", {stateCode, memWr}, 3'b101);
      check("R12 load addr", memAddr, (i % 16));
    end
    dmaIn = 0;
    tick(); check("R11 idle", {stateCode, memWr}, 3'b010);
    check("R12 wrapped r0", memAddr, 1);
    clear = 0; load = 0;
    tick(); check("R2 nop after clear", {stateCode, memWr, memRd}, 4'b1000);
    check("R2 r0 kept", memAddr, 1);
    tick(); check("R2 fetch", stateCode, 2'b00);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fetch();
    t_hold();
    t_dma_in();
    t_dma_out();
    t_prio();
    t_ie();
    t_clear_load();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule